// File: doc/BRIEF.md
# Configuration Pin Interrupt Monitor

This block watches twelve status lines coming from a programmable-logic configuration controller and turns their changes into one interrupt request for a host processor. Each line first passes through a two-flop synchroniser. Per line, software chooses whether it is watched at all (enable), whether its request is hidden from the interrupt output (mask), whether it is level or edge sensitive (type), and which logic value counts as active (polarity). The host reads the raw and masked request state and the synchronised line values over a simple 32-bit register bus, and writes ones to an end-of-interrupt register to retire latched edge requests.

Each line owns a two-state detector. Its states are DET_CLEAR (no request) and DET_PENDING (request held). The transitions are:
- **arm**: DET_CLEAR to DET_PENDING. It fires when the line is enabled and either the line is at its active value (level type) or a fresh active edge was seen (edge type).
- **drop**: DET_PENDING to DET_CLEAR. It fires when the line is disabled, or when a level line leaves its active value, or when an edge line gets an end-of-interrupt write in a cycle with no fresh edge.
- **hold**: the detector stays in DET_PENDING in every other case.

The raw status word is the set of lines whose detectors are in DET_PENDING. The masked status word is the raw word with the masked lines removed. The interrupt output is high whenever any masked status bit is set.

Line order, from bit 0 upward:
- bit 0: status (active-low)
- bit 1: configuration done
- bit 2: initialisation done
- bit 3: CRC error
- bit 4: protocol-path configuration done
- bit 5: partial-region ready
- bit 6: partial-region error
- bit 7: partial-region done
- bit 8: reconfigure-request pin
- bit 9: status pin
- bit 10: configuration-done pin
- bit 11: logic power good

Top module: `cfgmon_irq_top`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_out` is 0. Reset leaves all lines disabled, unmasked, level type and active-low.
- R2: The enable (0x830), mask (0x834), type (0x838) and polarity (0x83C) registers return the value last written to bits [11:0]. Bits [31:12] of every read are 0.
- R3: A read at 0x850 returns the `mon_in` value from two clock edges earlier. Bit n of the readback is `mon_in[n]`.
- R4: A line with type bit 0 (level) and enable bit 1 shows raw status (0x844) bit 1 while its synchronised value equals its polarity bit (1 = active-high, 0 = active-low). The raw bit follows the line with a latency of three edges after `mon_in` changes.
- R5: An end-of-interrupt write (0x84C) does not clear the raw bit of a level line whose input is still active.
- R6: A line with type bit 1 (edge) sets its raw bit on a change of its synchronised value into the active level. The bit stays set after the input returns inactive. A change away from the active level sets nothing.
- R7: Writing 1 to bit n of the end-of-interrupt register clears a held edge request on line n at the edge of the write. Bits written as 0 leave requests unchanged.
- R8: A line with enable bit 0 shows raw bit 0 from the edge after the disabling write onward, whatever its input does. A request held when the line was disabled is discarded, not restored on re-enabling.
- R9: Masked status (0x840) equals raw status AND NOT mask. `irq_out` is 1 exactly when masked status is non-zero.
- R10: Writes to the status, readback and unmapped addresses change nothing. Reads of the end-of-interrupt register and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_in | input | 12 | Asynchronous configuration status lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The latencies differ by result:
- Readback follows `mon_in` two edges later.
- A raw status bit follows an input change three edges later: two synchroniser stages, then the detector.
- A configuration write takes effect on the detector one edge after its own write edge.
- End-of-interrupt and mask writes act at their own write edge.

The bench drives inputs at the falling edge and counts rising edges to exactly these points. It reads `bus_rdata` shortly after the falling edge. For the readback it also checks one edge early, to confirm that the old value is still held. Every line is swept through all four type and polarity combinations. Each combination is checked for idle, active, inactive, end-of-interrupt, mask and disable behaviour.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;

    localparam int MON_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'h830;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 12'h834;
    localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h838;
    localparam logic [ADDR_W-1:0] OFS_POL      = 12'h83C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT    = 12'h840;
    localparam logic [ADDR_W-1:0] OFS_RSTAT    = 12'h844;
    localparam logic [ADDR_W-1:0] OFS_EOI      = 12'h84C;
    localparam logic [ADDR_W-1:0] OFS_READBACK = 12'h850;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_MASK,
        SEL_TYPE,
        SEL_POL,
        SEL_MSTAT,
        SEL_RSTAT,
        SEL_EOI,
        SEL_READBACK
    } reg_sel_t;

    typedef enum logic {
        DET_CLEAR   = 1'b0,
        DET_PENDING = 1'b1
    } det_state_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_t sel;
        case (addr)
            OFS_ENABLE:   sel = SEL_ENABLE;
            OFS_MASK:     sel = SEL_MASK;
            OFS_TYPE:     sel = SEL_TYPE;
            OFS_POL:      sel = SEL_POL;
            OFS_MSTAT:    sel = SEL_MSTAT;
            OFS_RSTAT:    sel = SEL_RSTAT;
            OFS_EOI:      sel = SEL_EOI;
            OFS_READBACK: sel = SEL_READBACK;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/cfgmon_sync.sv
module cfgmon_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfgmon_bit_det.sv
module cfgmon_bit_det
    import cfgmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic edge_mode,
    input  logic active_high,
    input  logic sample_now,
    input  logic sample_prev,
    input  logic eoi,
    output logic pending
);

    det_state_t state_q;
    det_state_t state_d;
    logic       act_now;
    logic       act_prev;
    logic       fresh_edge;

    // A line is active when its value equals the polarity bit.
    assign act_now    = ~(sample_now ^ active_high);
    assign act_prev   = ~(sample_prev ^ active_high);
    assign fresh_edge = act_now & ~act_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_CLEAR: begin
                // arm
                if (enable && (edge_mode ? fresh_edge : act_now)) begin
                    state_d = DET_PENDING;
                end
            end
            DET_PENDING: begin
                // drop; otherwise hold
                if (!enable) begin
                    state_d = DET_CLEAR;
                end else if (!edge_mode) begin
                    if (!act_now) begin
                        state_d = DET_CLEAR;
                    end
                end else if (eoi && !fresh_edge) begin
                    state_d = DET_CLEAR;
                end
            end
            default: state_d = DET_CLEAR;
        endcase
    end

    always_comb begin
        pending = (state_q == DET_PENDING);
    end

endmodule

// File: rtl/cfgmon_regs.sv
module cfgmon_regs
    import cfgmon_pkg::*;
#(
    parameter int MW = MON_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [MW-1:0]     raw_status,
    input  logic [MW-1:0]     sync_value,
    output logic [MW-1:0]     en_q,
    output logic [MW-1:0]     mask_q,
    output logic [MW-1:0]     type_q,
    output logic [MW-1:0]     pol_q,
    output logic [MW-1:0]     eoi_pulse
);

    reg_sel_t      sel;
    logic [MW-1:0] wfield;
    logic          unused_wdata_hi;

    assign sel             = decode_addr(bus_addr);
    assign wfield          = bus_wdata[MW-1:0];
    assign unused_wdata_hi = ^bus_wdata[DW-1:MW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_ENABLE: en_q   <= wfield;
                SEL_MASK:   mask_q <= wfield;
                SEL_TYPE:   type_q <= wfield;
                SEL_POL:    pol_q  <= wfield;
                default: ;
            endcase
        end
    end

    always_comb begin
        eoi_pulse = '0;
        if (bus_wr && (sel == SEL_EOI)) begin
            eoi_pulse = wfield;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_ENABLE:   bus_rdata[MW-1:0] = en_q;
            SEL_MASK:     bus_rdata[MW-1:0] = mask_q;
            SEL_TYPE:     bus_rdata[MW-1:0] = type_q;
            SEL_POL:      bus_rdata[MW-1:0] = pol_q;
            SEL_MSTAT:    bus_rdata[MW-1:0] = raw_status & ~mask_q;
            SEL_RSTAT:    bus_rdata[MW-1:0] = raw_status;
            SEL_READBACK: bus_rdata[MW-1:0] = sync_value;
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgmon_irq_top.sv
module cfgmon_irq_top
    import cfgmon_pkg::*;
#(
    parameter int MW          = MON_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MW-1:0]     mon_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_out
);

    logic [MW-1:0] sync_q;
    logic [MW-1:0] prev_q;
    logic [MW-1:0] raw_q;
    logic [MW-1:0] en_q;
    logic [MW-1:0] mask_q;
    logic [MW-1:0] type_q;
    logic [MW-1:0] pol_q;
    logic [MW-1:0] eoi_v;

    cfgmon_sync #(.W(MW), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mon_in),
        .sync_out (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_q;
        end
    end

    for (genvar b = 0; b < MW; b++) begin : g_det
        cfgmon_bit_det i_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (en_q[b]),
            .edge_mode   (type_q[b]),
            .active_high (pol_q[b]),
            .sample_now  (sync_q[b]),
            .sample_prev (prev_q[b]),
            .eoi         (eoi_v[b]),
            .pending     (raw_q[b])
        );
    end

    cfgmon_regs #(.MW(MW), .DW(DW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .raw_status (raw_q),
        .sync_value (sync_q),
        .en_q       (en_q),
        .mask_q     (mask_q),
        .type_q     (type_q),
        .pol_q      (pol_q),
        .eoi_pulse  (eoi_v)
    );

    assign irq_out = |(raw_q & ~mask_q);

endmodule

// File: rtl/cfgmon_checker.sv
module cfgmon_checker
    import cfgmon_pkg::*;
#(
    parameter int MW = MON_W,
    parameter int DW = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq_out,
    input logic [MW-1:0]     sync_q,
    input logic [MW-1:0]     prev_q,
    input logic [MW-1:0]     raw_q,
    input logic [MW-1:0]     en_q,
    input logic [MW-1:0]     mask_q,
    input logic [MW-1:0]     type_q,
    input logic [MW-1:0]     pol_q
);

    logic [MW-1:0] act_now;
    logic [MW-1:0] act_prev;
    logic [MW-1:0] edge_ev;
    logic [MW-1:0] eoi_seen;

    assign act_now  = ~(sync_q ^ pol_q);
    assign act_prev = ~(prev_q ^ pol_q);
    assign edge_ev  = act_now & ~act_prev;
    assign eoi_seen = (bus_wr && bus_addr == OFS_EOI) ? bus_wdata[MW-1:0] : '0;

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:MW] == '0); // R2

    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MSTAT) |-> (bus_rdata[MW-1:0] == (raw_q & ~mask_q))); // R9

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (raw_q != '0)); // R9

    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(en_q)) == '0)); // R8

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw_q ^ $past(act_now)) & $past(en_q & ~type_q)) == '0)); // R4

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~raw_q & $past(raw_q & en_q & type_q & ~eoi_seen)) == '0)); // R6

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(eoi_seen & type_q & ~edge_ev)) == '0)); // R7

endmodule

bind cfgmon_irq_top cfgmon_checker #(.MW(MW), .DW(DW)) i_cfgmon_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .sync_q    (sync_q),
    .prev_q    (prev_q),
    .raw_q     (raw_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .type_q    (type_q),
    .pol_q     (pol_q)
);

// File: tb/test_cfgmon_irq_top.sv
`timescale 1ns/1ps
module test_cfgmon_irq_top;

    localparam logic [11:0] A_EN   = 12'h830;
    localparam logic [11:0] A_MASK = 12'h834;
    localparam logic [11:0] A_TYPE = 12'h838;
    localparam logic [11:0] A_POL  = 12'h83C;
    localparam logic [11:0] A_MST  = 12'h840;
    localparam logic [11:0] A_RST  = 12'h844;
    localparam logic [11:0] A_EOI  = 12'h84C;
    localparam logic [11:0] A_RDB  = 12'h850;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mon_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgmon_irq_top i_cfgmon_irq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_in    (mon_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic sweep(input int b, input bit t, input bit p);
        logic [11:0] bit_m;
        logic [11:0] inact;
        bit_m = 12'(1) << b;
        inact = p ? 12'h000 : 12'hFFF;
        wr(A_EN, 32'h0);
        mon_in = inact;
        step(3);
        wr(A_TYPE, t ? 32'hFFF : 32'h0);
        wr(A_POL,  p ? 32'hFFF : 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_EOI,  32'hFFF);
        wr(A_EN, {20'h0, bit_m});
        step(2);
        chk_reg("R4/R6 idle", A_RST, 32'h0);
        // go active
        mon_in = inact ^ bit_m;
        step(3);
        chk_reg(t ? "R6 edge arm" : "R4 level arm", A_RST, {20'h0, bit_m});
        chk_reg("R9 masked open", A_MST, {20'h0, bit_m});
        check("R9 irq high", {31'h0, irq_out}, 32'h1);
        // end of interrupt while still active
        wr(A_EOI, 32'hFFF);
        chk_reg(t ? "R7 eoi clears edge" : "R5 eoi keeps level", A_RST, t ? 32'h0 : {20'h0, bit_m});
        mon_in = inact;
        step(3);
        chk_reg("R4/R6 leave active", A_RST, 32'h0);
        mon_in = inact ^ bit_m;
        step(3);
        chk_reg("R4/R6 re-arm", A_RST, {20'h0, bit_m});
        wr(A_MASK, {20'h0, bit_m});
        chk_reg("R9 masked hidden", A_MST, 32'h0);
        check("R9 irq masked", {31'h0, irq_out}, 32'h0);
        chk_reg("R9 raw under mask", A_RST, {20'h0, bit_m});
        wr(A_MASK, 32'h0);
        mon_in = inact;
        step(3);
        chk_reg(t ? "R6 edge latched" : "R4 level released", A_RST, t ? {20'h0, bit_m} : 32'h0);
        wr(A_EOI, 32'h0);
        chk_reg("R7 zero eoi no effect", A_RST, t ? {20'h0, bit_m} : 32'h0);
        wr(A_EOI, {20'h0, bit_m});
        chk_reg("R7 eoi bit clears", A_RST, 32'h0);
        check("R9 irq low", {31'h0, irq_out}, 32'h0);
        mon_in = inact ^ bit_m;
        step(3);
        wr(A_EN, 32'h0);
        step(1);
        chk_reg("R8 disable clears", A_RST, 32'h0);
        check("R8 irq off", {31'h0, irq_out}, 32'h0);
        mon_in = inact;
        step(3);
        mon_in = inact ^ bit_m;
        step(3);
        chk_reg("R8 disabled ignores input", A_RST, 32'h0);
        wr(A_EN, {20'h0, bit_m});
        step(1);
        chk_reg("R8 no restore", A_RST, t ? 32'h0 : {20'h0, bit_m});
    endtask

    initial begin
        logic [11:0] prev_pat;
        logic [11:0] pat;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk_reg("R1 enable", A_EN, 32'h0);
        chk_reg("R1 mask", A_MASK, 32'h0);
        chk_reg("R1 type", A_TYPE, 32'h0);
        chk_reg("R1 polarity", A_POL, 32'h0);
        chk_reg("R1 raw", A_RST, 32'h0);
        chk_reg("R1 masked", A_MST, 32'h0);
        chk_reg("R1 readback", A_RDB, 32'h0);
        check("R1 irq", {31'h0, irq_out}, 32'h0);

        // R2 register storage
        wr(A_EN, 32'hFFFF_FFFF);   chk_reg("R2 enable ones", A_EN, 32'hFFF);
        wr(A_MASK, 32'hA5A5_5A5A); chk_reg("R2 mask", A_MASK, 32'hA5A);
        wr(A_TYPE, 32'h1234_5C3B); chk_reg("R2 type", A_TYPE, 32'hC3B);
        wr(A_POL, 32'hFFFF_F00F);  chk_reg("R2 polarity", A_POL, 32'h00F);

        // R10 ignored writes
        wr(A_RST, 32'hFFF);
        wr(A_MST, 32'hFFF);
        wr(A_RDB, 32'hFFF);
        wr(12'h000, 32'hFFF);
        wr(12'h848, 32'hFFF);
        chk_reg("R10 enable untouched", A_EN, 32'hFFF);
        chk_reg("R10 mask untouched", A_MASK, 32'hA5A);
        chk_reg("R10 type untouched", A_TYPE, 32'hC3B);
        chk_reg("R10 polarity untouched", A_POL, 32'h00F);
        chk_reg("R10 unmapped 0x000", 12'h000, 32'h0);
        chk_reg("R10 unmapped 0x848", 12'h848, 32'h0);
        chk_reg("R10 eoi reads zero", A_EOI, 32'h0);
        wr(A_EN, 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_TYPE, 32'h0);
        wr(A_POL, 32'h0);

        // R3 readback latency and bit order
        prev_pat = mon_in;
        for (int i = 0; i < 14; i++) begin
            pat = (i < 12) ? (12'(1) << i) : ((i == 12) ? 12'hFFF : 12'h5A3);
            mon_in = pat;
            step(1);
            chk_reg("R3 readback one edge", A_RDB, {20'h0, prev_pat});
            step(1);
            chk_reg("R3 readback two edges", A_RDB, {20'h0, pat});
            prev_pat = pat;
        end

        // R4..R9 sweep over every line, type and polarity
        for (int b = 0; b < 12; b++) begin
            for (int t = 0; t < 2; t++) begin
                for (int p = 0; p < 2; p++) begin
                    sweep(b, t[0], p[0]);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule